// File: doc/BRIEF.md
# Bus-Written Palette Lookup RAM

This block is the color table of a display controller. Pixel data arrives as a short palette index, and the block turns that index into a wide true-color word. A CPU fills the table through a Wishbone slave port that accepts only writes. Any attempt to read through that port is refused with an error response. Palette contents cannot be read back on the bus.

The pixel side is a purely combinational lookup. The color output follows the index input with no clock in between. While the blanking input is high, the output is forced to zero.

The slave port can sit in a daisy chain of slaves. Acknowledge, error and read-data inputs from a neighbour are merged into the block's own bus outputs. Because the block never supplies read data itself, its data output simply passes the chained data through.

Top module: `palette_lut_ram`

## Requirements
- R1: While cyc_i, stb_i and we_i are all high, ack_o is high and err_o is low in that same cycle (chain inputs low), so a held burst completes one write per clock.
- R2: A write stores dat_i[COLOR_W-1:0] into entry adr_i[INDEX_W-1:0]. The new value appears on pix_color_o from the first clock edge after the write cycle.
- R3: While cyc_i and stb_i are high with we_i low, err_o is high and ack_o is low (chain inputs low), and no palette entry changes.
- R4: If cyc_i or stb_i is low, the block raises neither ack_o nor err_o and leaves every entry unchanged.
- R5: ack_o is the OR of the local acknowledge and chain_ack_i, and err_o is the OR of the local error and chain_err_i.
- R6: dat_o always equals chain_dat_i.
- R7: With blank_i low, pix_color_o equals the entry selected by pix_idx_i, combinationally and with no clock latency.
- R8: While blank_i is high, every bit of pix_color_o is 0 whatever the index.
- R9: With rst_i high at a clock edge, every entry is cleared to zero and no write is committed on that edge.
- R10: Address bits at and above INDEX_W, and data bits at and above COLOR_W, have no effect on which entry is written or on its stored value.
- R11: The local acknowledge and the local error are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high, clears the table |
| cyc_i | input | 1 | Bus cycle frame |
| stb_i | input | 1 | Strobe selecting this slave |
| we_i | input | 1 | Write enable; low means a read request, which is rejected |
| adr_i | input | BUS_AW | Bus address; low INDEX_W bits choose the entry |
| dat_i | input | BUS_DW | Write data; low COLOR_W bits are stored |
| dat_o | output | BUS_DW | Read data to master, taken from the chain |
| ack_o | output | 1 | Merged acknowledge |
| err_o | output | 1 | Merged error |
| chain_ack_i | input | 1 | Acknowledge from a neighbouring slave |
| chain_err_i | input | 1 | Error from a neighbouring slave |
| chain_dat_i | input | BUS_DW | Read data from a neighbouring slave |
| blank_i | input | 1 | Forces the color output to zero while high |
| pix_idx_i | input | INDEX_W | Palettized pixel index |
| pix_color_o | output | COLOR_W | True-color lookup result |

## Verification
The clocked checks assume that the bus inputs are stable across each rising clock edge, and that nothing outside a reset pulse depends on the table's contents before the first edge with rst_i high. The bench drives every input on the falling edge and holds reset through at least two rising edges before any traffic starts, which meets both assumptions. Chain inputs are held low while the local acknowledge and error are checked, so only the merge tests exercise the OR.

// File: rtl/palette_lut_pkg.sv
package palette_lut_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE   = 2'd0,
      ACC_WRITE  = 2'd1,
      ACC_REJECT = 2'd2
   } acc_kind_t;

   function automatic acc_kind_t classify_access(input logic cyc, input logic stb,
                                                 input logic we);
      if (!(cyc && stb)) return ACC_IDLE;
      if (we)            return ACC_WRITE;
      return ACC_REJECT;
   endfunction

endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode
   import palette_lut_pkg::*;
#(
   parameter int BUS_AW  = 12,
   parameter int BUS_DW  = 32,
   parameter int INDEX_W = 8,
   parameter int COLOR_W = 24
) (
   input  logic               cyc_i,
   input  logic               stb_i,
   input  logic               we_i,
   input  logic [BUS_AW-1:0]  adr_i,
   input  logic [BUS_DW-1:0]  dat_i,
   output logic               loc_ack_o,
   output logic               loc_err_o,
   output logic               wr_en_o,
   output logic [INDEX_W-1:0] wr_idx_o,
   output logic [COLOR_W-1:0] wr_val_o
);

   acc_kind_t kind;

   always_comb begin
      kind      = classify_access(cyc_i, stb_i, we_i);
      loc_ack_o = (kind == ACC_WRITE);
      loc_err_o = (kind == ACC_REJECT);
      wr_en_o   = (kind == ACC_WRITE);
   end

   generate
      if (BUS_AW == INDEX_W) begin : g_adr_full
         assign wr_idx_o = adr_i;
      end else begin : g_adr_slice
         logic [BUS_AW-INDEX_W-1:0] adr_hi_unused;
         assign wr_idx_o      = adr_i[INDEX_W-1:0];
         assign adr_hi_unused = adr_i[BUS_AW-1:INDEX_W];
      end

      if (BUS_DW == COLOR_W) begin : g_dat_full
         assign wr_val_o = dat_i;
      end else begin : g_dat_slice
         logic [BUS_DW-COLOR_W-1:0] dat_hi_unused;
         assign wr_val_o      = dat_i[COLOR_W-1:0];
         assign dat_hi_unused = dat_i[BUS_DW-1:COLOR_W];
      end
   endgenerate

   always_comb begin
      assert_ack_err_excl_R11 : assert (!(loc_ack_o && loc_err_o));
      assert_err_no_write_R3  : assert (!(loc_err_o && wr_en_o));
   end

endmodule

// File: rtl/pal_entry_bank.sv
module pal_entry_bank #(
   parameter int INDEX_W = 8,
   parameter int COLOR_W = 24,
   localparam int DEPTH  = 1 << INDEX_W
) (
   input  logic                            clk_i,
   input  logic                            rst_i,
   input  logic                            wr_en_i,
   input  logic [INDEX_W-1:0]              wr_idx_i,
   input  logic [COLOR_W-1:0]              wr_val_i,
   output logic [DEPTH-1:0][COLOR_W-1:0]   tbl_o
);

   logic [DEPTH-1:0] sel_onehot;

   always_comb begin
      sel_onehot = '0;
      if (wr_en_i) sel_onehot[wr_idx_i] = 1'b1;
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_entry
         logic [COLOR_W-1:0] ent_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)              ent_q <= '0;
            else if (sel_onehot[g]) ent_q <= wr_val_i;
         end
         assign tbl_o[g] = ent_q;
      end
   endgenerate

   always_comb begin
      assert_sel_onehot_R2 : assert ($onehot0(sel_onehot));
   end

   assert_write_lands_R2 : assert property (@(posedge clk_i) disable iff (rst_i)
      wr_en_i |=> (tbl_o[$past(wr_idx_i)] == $past(wr_val_i)));

   assert_hold_no_write_R4 : assert property (@(posedge clk_i) disable iff (rst_i)
      !wr_en_i |=> $stable(tbl_o));

   assert_reset_clears_R9 : assert property (@(posedge clk_i)
      rst_i |=> (tbl_o == '0));

endmodule

// File: rtl/pal_color_lookup.sv
module pal_color_lookup #(
   parameter int INDEX_W = 8,
   parameter int COLOR_W = 24,
   localparam int DEPTH  = 1 << INDEX_W
) (
   input  logic [DEPTH-1:0][COLOR_W-1:0] tbl_i,
   input  logic [INDEX_W-1:0]            idx_i,
   input  logic                          blank_i,
   output logic [COLOR_W-1:0]            color_o
);

   logic [COLOR_W-1:0] raw_color;

   assign raw_color = tbl_i[idx_i];
   assign color_o   = blank_i ? '0 : raw_color;

endmodule

// File: rtl/palette_lut_ram.sv
module palette_lut_ram #(
   parameter int COLOR_W = 24,
   parameter int INDEX_W = 8,
   parameter int BUS_DW  = 32,
   parameter int BUS_AW  = 12
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               cyc_i,
   input  logic               stb_i,
   input  logic               we_i,
   input  logic [BUS_AW-1:0]  adr_i,
   input  logic [BUS_DW-1:0]  dat_i,
   output logic [BUS_DW-1:0]  dat_o,
   output logic               ack_o,
   output logic               err_o,
   input  logic               chain_ack_i,
   input  logic               chain_err_i,
   input  logic [BUS_DW-1:0]  chain_dat_i,
   input  logic               blank_i,
   input  logic [INDEX_W-1:0] pix_idx_i,
   output logic [COLOR_W-1:0] pix_color_o
);

   localparam int DEPTH = 1 << INDEX_W;

   generate
      if (INDEX_W < 1 || INDEX_W > 12) begin : g_bad_index
         $error("palette_lut_ram: INDEX_W must lie in 1..12");
      end
      if (COLOR_W < 1) begin : g_bad_color
         $error("palette_lut_ram: COLOR_W must be positive");
      end
      if (BUS_AW < INDEX_W) begin : g_bad_aw
         $error("palette_lut_ram: BUS_AW must cover INDEX_W");
      end
      if (BUS_DW < COLOR_W) begin : g_bad_dw
         $error("palette_lut_ram: BUS_DW must cover COLOR_W");
      end
   endgenerate

   logic                          loc_ack;
   logic                          loc_err;
   logic                          wr_en;
   logic [INDEX_W-1:0]            wr_idx;
   logic [COLOR_W-1:0]            wr_val;
   logic [DEPTH-1:0][COLOR_W-1:0] tbl;

   pal_bus_decode #(
      .BUS_AW (BUS_AW),
      .BUS_DW (BUS_DW),
      .INDEX_W(INDEX_W),
      .COLOR_W(COLOR_W)
   ) decode_i (
      .cyc_i    (cyc_i),
      .stb_i    (stb_i),
      .we_i     (we_i),
      .adr_i    (adr_i),
      .dat_i    (dat_i),
      .loc_ack_o(loc_ack),
      .loc_err_o(loc_err),
      .wr_en_o  (wr_en),
      .wr_idx_o (wr_idx),
      .wr_val_o (wr_val)
   );

   pal_entry_bank #(
      .INDEX_W(INDEX_W),
      .COLOR_W(COLOR_W)
   ) bank_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .wr_en_i (wr_en),
      .wr_idx_i(wr_idx),
      .wr_val_i(wr_val),
      .tbl_o   (tbl)
   );

   pal_color_lookup #(
      .INDEX_W(INDEX_W),
      .COLOR_W(COLOR_W)
   ) lookup_i (
      .tbl_i  (tbl),
      .idx_i  (pix_idx_i),
      .blank_i(blank_i),
      .color_o(pix_color_o)
   );

   assign ack_o = loc_ack | chain_ack_i;
   assign err_o = loc_err | chain_err_i;
   assign dat_o = chain_dat_i;

   assert_idle_quiet_ack_R4 : assert property (@(posedge clk_i) disable iff (rst_i)
      (!(cyc_i && stb_i) && !chain_ack_i) |-> !ack_o);

   assert_idle_quiet_err_R4 : assert property (@(posedge clk_i) disable iff (rst_i)
      (!(cyc_i && stb_i) && !chain_err_i) |-> !err_o);

   assert_chain_ack_R5 : assert property (@(posedge clk_i) disable iff (rst_i)
      chain_ack_i |-> ack_o);

   assert_blank_dark_R8 : assert property (@(posedge clk_i) disable iff (rst_i)
      blank_i |-> (pix_color_o == '0));

endmodule

// File: tb/palette_lut_ram_tb.sv
module palette_lut_ram_tb_top;

   localparam int COLOR_W = 24;
   localparam int INDEX_W = 8;
   localparam int BUS_DW  = 32;
   localparam int BUS_AW  = 12;
   localparam int DEPTH   = 1 << INDEX_W;

   logic               clk_i = 1'b0;
   logic               rst_i;
   logic               cyc_i, stb_i, we_i;
   logic [BUS_AW-1:0]  adr_i;
   logic [BUS_DW-1:0]  dat_i;
   logic [BUS_DW-1:0]  dat_o;
   logic               ack_o, err_o;
   logic               chain_ack_i, chain_err_i;
   logic [BUS_DW-1:0]  chain_dat_i;
   logic               blank_i;
   logic [INDEX_W-1:0] pix_idx_i;
   logic [COLOR_W-1:0] pix_color_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [COLOR_W-1:0] model [DEPTH];

   always #2.5 clk_i = ~clk_i;

   palette_lut_ram #(
      .COLOR_W(COLOR_W), .INDEX_W(INDEX_W), .BUS_DW(BUS_DW), .BUS_AW(BUS_AW)
   ) dut_i (
      .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
      .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o), .err_o(err_o),
      .chain_ack_i(chain_ack_i), .chain_err_i(chain_err_i),
      .chain_dat_i(chain_dat_i), .blank_i(blank_i), .pix_idx_i(pix_idx_i),
      .pix_color_o(pix_color_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_idle();
      cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0; adr_i = '0; dat_i = '0;
   endtask

   // lookup with blank low, compare against the model
   task automatic look(input logic [INDEX_W-1:0] idx, input string req);
      blank_i   = 1'b0;
      pix_idx_i = idx;
      #1;
      chk(pix_color_o == model[idx], req, 64'(pix_color_o), 64'(model[idx]));
   endtask

   // one write beat driven on the falling edge; ack checked in the same cycle
   task automatic write_beat(input logic [BUS_AW-1:0] a, input logic [BUS_DW-1:0] d);
      cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b1; adr_i = a; dat_i = d;
      #1;
      chk(ack_o == 1'b1 && err_o == 1'b0, "R1 write ack", {62'd0, ack_o, err_o}, 64'h2);
      model[a[INDEX_W-1:0]] = d[COLOR_W-1:0];
      @(negedge clk_i);
   endtask

   task automatic t_reset_state();
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
         pix_idx_i = INDEX_W'(i); blank_i = 1'b0;
         #0.1;
         if (pix_color_o !== '0) bad++;
      end
      chk(bad == 0, "R9 table clear after reset", 64'(bad), 64'd0);
      chk(ack_o == 1'b0 && err_o == 1'b0, "R4 idle after reset",
          {62'd0, ack_o, err_o}, 64'd0);
   endtask

   task automatic t_single_writes();
      @(negedge clk_i);
      write_beat(12'h000, 32'h00A1B2C3);
      bus_idle();
      look(8'h00, "R2 entry 0 stored");
      @(negedge clk_i);
      write_beat(12'h0FF, 32'h00FFEEDD);
      bus_idle();
      look(8'hFF, "R2 entry 255 stored");
      look(8'h00, "R2 entry 0 unaffected");
   endtask

   task automatic t_burst();
      @(negedge clk_i);
      for (int k = 0; k < 8; k++)
         write_beat(BUS_AW'(16 + k), BUS_DW'(32'h00100000 + 32'h1111 * k));
      bus_idle();
      for (int k = 0; k < 8; k++) look(INDEX_W'(16 + k), "R2 burst entries");
   endtask

   task automatic t_read_reject();
      @(negedge clk_i);
      cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b0; adr_i = 12'h010; dat_i = 32'h00BADBAD;
      #1;
      chk(err_o == 1'b1 && ack_o == 1'b0, "R3 read rejected",
          {62'd0, ack_o, err_o}, 64'h1);
      @(negedge clk_i);
      // read then write phase of a read-modify-write: only the write may land
      look(8'h10, "R3 no write on rejected read");
      we_i = 1'b1; dat_i = 32'h00C0FFEE;
      #1;
      chk(ack_o == 1'b1 && err_o == 1'b0, "R1 rmw write phase acked",
          {62'd0, ack_o, err_o}, 64'h2);
      model[8'h10] = 24'hC0FFEE;
      @(negedge clk_i);
      bus_idle();
      look(8'h10, "R2 rmw write stored");
   endtask

   task automatic t_idle_noeffect();
      @(negedge clk_i);
      cyc_i = 1'b1; stb_i = 1'b0; we_i = 1'b1; adr_i = 12'h011; dat_i = 32'h00DEAD01;
      #1;
      chk(ack_o == 1'b0 && err_o == 1'b0, "R4 no strobe quiet",
          {62'd0, ack_o, err_o}, 64'd0);
      @(negedge clk_i);
      cyc_i = 1'b0; stb_i = 1'b1;
      #1;
      chk(ack_o == 1'b0 && err_o == 1'b0, "R4 no cycle quiet",
          {62'd0, ack_o, err_o}, 64'd0);
      @(negedge clk_i);
      bus_idle();
      look(8'h11, "R4 entry untouched");
   endtask

   task automatic t_chain();
      @(negedge clk_i);
      chain_ack_i = 1'b1;
      #1;
      chk(ack_o == 1'b1 && err_o == 1'b0, "R5 chain ack merged",
          {62'd0, ack_o, err_o}, 64'h2);
      chain_ack_i = 1'b0; chain_err_i = 1'b1;
      #1;
      chk(ack_o == 1'b0 && err_o == 1'b1, "R5 chain err merged",
          {62'd0, ack_o, err_o}, 64'h1);
      chain_err_i = 1'b0;
      chain_dat_i = 32'h5A5AA5A5;
      #1;
      chk(dat_o == 32'h5A5AA5A5, "R6 dat passthrough", 64'(dat_o), 64'h5A5AA5A5);
      chain_dat_i = 32'h0F0F1234;
      cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b0; adr_i = 12'h020;
      #1;
      chk(dat_o == 32'h0F0F1234, "R6 dat passthrough on reject",
          64'(dat_o), 64'h0F0F1234);
      @(negedge clk_i);
      bus_idle();
      chain_dat_i = '0;
   endtask

   task automatic t_blank_and_comb();
      blank_i = 1'b1; pix_idx_i = 8'hFF;
      #1;
      chk(pix_color_o == '0, "R8 blank forces zero", 64'(pix_color_o), 64'd0);
      pix_idx_i = 8'h10;
      #1;
      chk(pix_color_o == '0, "R8 blank zero other index", 64'(pix_color_o), 64'd0);
      blank_i = 1'b0;
      #0.5;
      chk(pix_color_o == model[8'h10], "R7 unblank immediate",
          64'(pix_color_o), 64'(model[8'h10]));
      pix_idx_i = 8'h00;
      #0.5;
      chk(pix_color_o == model[8'h00], "R7 index change without clock",
          64'(pix_color_o), 64'(model[8'h00]));
   endtask

   task automatic t_alias();
      @(negedge clk_i);
      write_beat(12'hA33, 32'hFF123456);
      bus_idle();
      look(8'h33, "R10 high bits ignored");
      look(8'h32, "R10 neighbour unaffected");
   endtask

   task automatic t_reset_blocks_write();
      @(negedge clk_i);
      rst_i = 1'b1;
      cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b1; adr_i = 12'h040; dat_i = 32'h00777777;
      @(negedge clk_i);
      bus_idle();
      @(negedge clk_i);
      rst_i = 1'b0;
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      look(8'h40, "R9 write during reset dropped");
      look(8'hFF, "R9 old entry cleared");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      rst_i = 1'b1;
      bus_idle();
      chain_ack_i = 1'b0; chain_err_i = 1'b0; chain_dat_i = '0;
      blank_i = 1'b0; pix_idx_i = '0;
      repeat (3) @(negedge clk_i);
      rst_i = 1'b0;
      t_reset_state();
      t_single_writes();
      t_burst();
      t_read_reject();
      t_idle_noeffect();
      t_chain();
      t_blank_and_comb();
      t_alias();
      t_reset_blocks_write();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule